// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address for one port of a synchronous memory. A caller strobes in a start address, after which the block steps the address by one on each enabled clock. A programmable mask decides which low-order bits take part in counting. Bits above the mask never change during counting, so a burst wraps inside a power-of-two window whose base is set by the start address.

A clear input zeroes only the counting bits, and it wins over both load and increment. An active-low flag drops when an increment brings the counting field to all ones, which marks the last word before the burst wraps. A mode select switches the load path from the counter to the mask register. The same select picks which of the two values is shown on a registered readback output.

Top module: `burst_addr_gen`

## Requirements
- R1: In counter mode (`sel_mask_n`=1), with `clr_n`=1 and `strobe_n`=0, `cur_addr` equals `addr_in` after the next rising edge.
- R2: In counter mode, with `clr_n`=1, `strobe_n`=1 and `adv_n`=0, `cur_addr` increments by one inside the mask field on each edge. With `adv_n`=1, the address holds.
- R3: In counter mode, `clr_n`=0 clears every bit of the counter that is set in the mask and keeps the other bits. This takes effect whatever the values of `strobe_n` and `adv_n`.
- R4: `wrap_irq_n` goes to 0 on the edge where an increment makes all mask-selected bits 1 (non-zero mask only). It returns to 1 on the next load, clear or increment in counter mode.
- R5: An increment with all mask-selected bits at 1 wraps those bits to 0. The bits outside the mask are left unchanged.
- R6: In mask mode (`sel_mask_n`=0), `strobe_n`=0 writes the mask so that bit i is 1 exactly when `addr_in` bits 0..i are all 1. In mask mode, the counter and `wrap_irq_n` do not change, and `adv_n` and `clr_n` are ignored.
- R7: `rb_data` shows, one edge after a cycle, the updated counter if `sel_mask_n` was 1 in that cycle, or the updated mask if it was 0.
- R8: A synchronous `rst` sets the counter to 0, the mask to all ones, `wrap_irq_n` to 1 and `rb_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| sel_mask_n | input | 1 | 0 selects the mask register, 1 selects the counter |
| strobe_n | input | 1 | Active-low load of `addr_in` |
| adv_n | input | 1 | Active-low increment enable |
| clr_n | input | 1 | Active-low clear of the masked counter bits |
| addr_in | input | ADDR_W | External address or mask value |
| cur_addr | output | ADDR_W | Current counter address |
| rb_data | output | ADDR_W | Registered readback of the counter or the mask |
| wrap_irq_n | output | 1 | Active-low flag: counting field is all ones |

## Verification
Every result comes from a register that is updated on the first rising edge after its controls are presented: `cur_addr`, `rb_data` and `wrap_irq_n` all change one edge after the stimulus. The bench changes the inputs on the falling edge and samples 1 ns after the next rising edge. Each check therefore looks at exactly one update. Mask-mode checks read `cur_addr` after the mask-mode cycle to show that the counter did not move.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Force a contiguous run of ones from bit 0: bit i set only if bits 0..i set.
  function automatic logic [63:0] prefix_ones(input logic [63:0] v, input int w);
    logic [63:0] m;
    m = '0;
    m[0] = v[0];
    for (int i = 1; i < 64; i++) begin
      if (i < w) m[i] = m[i-1] & v[i];
    end
    return m;
  endfunction
endpackage

// File: rtl/mask_store.sv
module mask_store #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_val,
  output logic [ADDR_W-1:0] mask_q,
  output logic [ADDR_W-1:0] mask_d
);
  import burst_pkg::*;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  logic [63:0] wide_in;
  logic [63:0] wide_m;

  always_comb begin
    wide_in = '0;
    wide_in[ADDR_W-1:0] = wr_val;
    wide_m = prefix_ones(wide_in, ADDR_W);
    mask_d = wr_en ? wide_m[ADDR_W-1:0] : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= mask_d;
  end

  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (rst)
    ((mask_q & (mask_q + ONE)) == '0)); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (mask_q == $past(mask_q))); // R6
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_mode,
  input  logic              strobe_n,
  input  logic              clr_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] cnt_q,
  output logic [ADDR_W-1:0] cnt_d,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  logic [ADDR_W-1:0] stepped;
  logic              irq_d;

  always_comb begin
    stepped = (cnt_q & ~mask) | ((cnt_q + ONE) & mask);
    cnt_d   = cnt_q;
    irq_d   = irq_n;
    if (cnt_mode) begin
      if (!clr_n) begin
        cnt_d = cnt_q & ~mask;
        irq_d = 1'b1;
      end else if (!strobe_n) begin
        cnt_d = addr_in;
        irq_d = 1'b1;
      end else if (!adv_n) begin
        cnt_d = stepped;
        irq_d = !((mask != '0) && ((stepped & mask) == mask));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_n <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      irq_n <= irq_d;
    end
  end

  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (cnt_mode && clr_n && !strobe_n) |=> (cnt_q == $past(addr_in))); // R1
  AST_CLEAR_FIELD: assert property (@(posedge clk) disable iff (rst)
    (cnt_mode && !clr_n) |=> (((cnt_q & $past(mask)) == '0) &&
      ((cnt_q & ~$past(mask)) == ($past(cnt_q) & ~$past(mask))))); // R3
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (cnt_mode && strobe_n) |=> ((cnt_q & ~$past(mask)) == ($past(cnt_q) & ~$past(mask)))); // R5
  AST_IRQ_AT_ONES: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> ((cnt_q & mask) == mask)); // R4
  AST_MASK_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !cnt_mode |=> ((cnt_q == $past(cnt_q)) && (irq_n == $past(irq_n)))); // R6
endmodule

// File: rtl/readback_reg.sv
module readback_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              show_cnt,
  input  logic [ADDR_W-1:0] cnt_next,
  input  logic [ADDR_W-1:0] mask_next,
  output logic [ADDR_W-1:0] rb_q
);
  always_ff @(posedge clk) begin
    if (rst)           rb_q <= '0;
    else if (show_cnt) rb_q <= cnt_next;
    else               rb_q <= mask_next;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_mask_n,
  input  logic              strobe_n,
  input  logic              adv_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] rb_data,
  output logic              wrap_irq_n
);
  logic [ADDR_W-1:0] mask_q, mask_d, cnt_d;

  mask_store #(.ADDR_W(ADDR_W)) u_mask (
    .clk(clk), .rst(rst), .wr_en(!sel_mask_n && !strobe_n),
    .wr_val(addr_in), .mask_q(mask_q), .mask_d(mask_d)
  );

  count_core #(.ADDR_W(ADDR_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_mode(sel_mask_n), .strobe_n(strobe_n),
    .clr_n(clr_n), .adv_n(adv_n), .addr_in(addr_in), .mask(mask_q),
    .cnt_q(cur_addr), .cnt_d(cnt_d), .irq_n(wrap_irq_n)
  );

  readback_reg #(.ADDR_W(ADDR_W)) u_rb (
    .clk(clk), .rst(rst), .show_cnt(sel_mask_n),
    .cnt_next(cnt_d), .mask_next(mask_d), .rb_q(rb_data)
  );

  AST_RB_MATCH: assert property (@(posedge clk) disable iff (rst)
    sel_mask_n |=> (rb_data == cur_addr)); // R7
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int CLK_NS = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_mask_n = 1'b1, strobe_n = 1'b1, adv_n = 1'b1, clr_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] cur_addr, rb_data;
  logic wrap_irq_n;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .sel_mask_n(sel_mask_n), .strobe_n(strobe_n),
    .adv_n(adv_n), .clr_n(clr_n), .addr_in(addr_in),
    .cur_addr(cur_addr), .rb_data(rb_data), .wrap_irq_n(wrap_irq_n)
  );

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the rising edge
  task automatic step(input logic s, input logic ld, input logic cl, input logic ad,
                      input logic [AW-1:0] a);
    @(negedge clk);
    sel_mask_n = s; strobe_n = ld; clr_n = cl; adv_n = ad; addr_in = a;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R8 addr", cur_addr, 16'h0000);
    chk("R8 rb", rb_data, 16'h0000);
    chk("R8 irq", {15'd0, wrap_irq_n}, 16'h0001);
  endtask

  task automatic t_load();
    step(1, 0, 1, 1, 16'h1234);
    chk("R1 load", cur_addr, 16'h1234);
    chk("R7 rb counter", rb_data, 16'h1234);
  endtask

  task automatic t_count();
    step(1, 1, 1, 0, 16'h0);
    step(1, 1, 1, 0, 16'h0);
    chk("R2 two steps", cur_addr, 16'h1236);
    step(1, 1, 1, 1, 16'hFFFF);
    chk("R2 hold", cur_addr, 16'h1236);
  endtask

  task automatic t_mask();
    step(0, 0, 0, 0, 16'h00F7);
    chk("R6 addr frozen", cur_addr, 16'h1236);
    chk("R6 mask prefix", rb_data, 16'h0007);
    step(0, 1, 0, 0, 16'hFFFF);
    chk("R6 ignore clr/adv", cur_addr, 16'h1236);
    chk("R7 rb mask", rb_data, 16'h0007);
  endtask

  task automatic t_wrap();
    step(1, 0, 1, 1, 16'hAB05);
    step(1, 1, 1, 0, 16'h0);
    chk("R2 masked step", cur_addr, 16'hAB06);
    chk("R4 irq high before", {15'd0, wrap_irq_n}, 16'h0001);
    step(1, 1, 1, 0, 16'h0);
    chk("R4 at ones", cur_addr, 16'hAB07);
    chk("R4 irq low", {15'd0, wrap_irq_n}, 16'h0000);
    step(0, 1, 1, 0, 16'h0);
    chk("R6 irq kept", {15'd0, wrap_irq_n}, 16'h0000);
    step(1, 1, 1, 0, 16'h0);
    chk("R5 wrap", cur_addr, 16'hAB00);
    chk("R4 irq released", {15'd0, wrap_irq_n}, 16'h0001);
  endtask

  task automatic t_clear();
    step(1, 0, 1, 1, 16'hAB05);
    step(1, 0, 0, 0, 16'hFFFF);
    chk("R3 clear wins", cur_addr, 16'hAB00);
    step(1, 0, 1, 1, 16'hAB06);
    step(1, 1, 1, 0, 16'h0);
    chk("R4 irq low again", {15'd0, wrap_irq_n}, 16'h0000);
    step(1, 0, 1, 1, 16'h0C17);
    chk("R4 load releases", {15'd0, wrap_irq_n}, 16'h0001);
    chk("R1 load over ones", cur_addr, 16'h0C17);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_load();
    t_count();
    t_mask();
    t_wrap();
    t_clear();
    finish_run();
  end
endmodule